// File: doc/BRIEF.md
# Execute Packet Issue-Rule Checker

This block examines one execute packet for a two-sided VLIW datapath and decides whether the packet may issue. A packet holds up to eight already-decoded instruction descriptors, one per slot. Each descriptor names the functional unit (L, S, M or D) and the side (A or B) it runs on. It also carries data and address cross-path flags, destination and operand register information, a predicate, and flags for compact encoding and control-register access.

The checker applies the datapath's issue rules across the whole packet: unit occupancy, cross-path budgets per direction, register side and alignment, predicate registers, and control-register unit restrictions. It returns a single legal flag and an error mask with one bit per rule. Slots whose valid bit is low take no part in any rule.

A two-state controller handles timing. In ST_IDLE no result is being presented. A cycle with `in_vld_i` high captures the verdict and moves to ST_SHOW, where `out_vld_o` is high. ST_SHOW stays in ST_SHOW while further packets arrive back to back, and returns to ST_IDLE on the first cycle without a packet. Reset enters ST_IDLE with a cleared verdict.

Top module: `pkt_rule_check`

## Requirements
- R1: A packet presented with `in_vld_i` high at a rising clock edge produces its verdict on `legal_o`/`err_o` after that edge, with `out_vld_o` high for that one cycle. When `in_vld_i` is low, `out_vld_o` falls and `legal_o`/`err_o` keep their previous values. After reset, `out_vld_o`, `legal_o` and `err_o` are all 0.
- R2: Slot s occupies `pkt_i[s*32 +: 32]`. The bit fields are: [0] valid, [2:1] unit (0=L, 1=S, 2=M, 3=D), [3] unit side (0=A, 1=B), [4] data cross path, [9:5] destination index, [10] destination side, [12:11] width class (0=single, 1=40-bit pair, 2=64-bit pair, 3=quad), [17:13] base index, [18] address cross path, [20:19] memory op (0=none, 1=load, 2=store, 3=none), [21] store-data side, [22] predicated, [23] predicate side, [28:24] predicate index, [29] predicate invert, [30] compact, [31] control access. `legal_o` is 1 exactly when `err_o` is all zero. A packet with no valid slot is legal.
- R3: `err_o[0]` is set when two valid slots name the same unit and side.
- R4: `err_o[1]` is set when more than one valid side-A slot uses a data cross path (B to A). `err_o[2]` is set when more than one valid side-B slot uses a data cross path (A to B).
- R5: `err_o[3]` is set when a valid slot's destination side differs from its unit side. The one exemption is a D-unit load or store that uses an address cross path.
- R6: `err_o[4]` is set when more than one valid D slot on the same side uses an address cross path.
- R7: `err_o[5]` is set when valid D slots exist on both sides and exactly one side uses an address cross path.
- R8: `err_o[6]` is set when a D-unit load using an address cross path has its destination on the D unit's own side. It is also set when a D-unit store using an address cross path has its store-data register on the D unit's own side.
- R9: `err_o[7]` is set when a pair width class (1 or 2) has an odd base index, or when the quad class has a base index that is not a multiple of four.
- R10: `err_o[8]` is set when a predicated slot names a predicate index above 2 on either side. The invert flag has no effect on legality.
- R11: `err_o[9]` is set when a compact slot is predicated.
- R12: `err_o[10]` is set when a control-access slot runs anywhere other than the S unit of side B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Packet present this cycle |
| pkt_i | input | NSLOT*32 | Packed slot descriptors |
| out_vld_o | output | 1 | Verdict updated this cycle |
| legal_o | output | 1 | Packet obeys every rule |
| err_o | output | 11 | One bit per violated rule |

## Verification
Fully legal packets with a random mix of units, widths, predicates and single cross paths show that no rule fires spuriously. The same packets with one descriptor bit flipped show that each rule fires alone, at its own mask bit. Directed packets place pairs of cross paths in one direction against one in each direction. They also contrast mixed against matched address cross-path use on the two D units, and aligned against misaligned pair and quad bases, which separates each boundary from its neighbour. Gaps between packets, and back-to-back packets, separate the hold behaviour from the update behaviour of the output register.

// File: rtl/pkt_rule_pkg.sv
package pkt_rule_pkg;
    localparam int REG_W  = 5;
    localparam int DESC_W = 32;
    localparam int ERR_W  = 11;
    localparam int NUNIT  = 8;

    // error mask bit positions
    localparam int E_DUP   = 0;
    localparam int E_XBA   = 1;
    localparam int E_XAB   = 2;
    localparam int E_DSIDE = 3;
    localparam int E_AXDIR = 4;
    localparam int E_AXMIX = 5;
    localparam int E_AXREG = 6;
    localparam int E_ALIGN = 7;
    localparam int E_PRED  = 8;
    localparam int E_CMPCT = 9;
    localparam int E_CTRL  = 10;

    typedef enum logic [1:0] {U_L = 2'd0, U_S = 2'd1, U_M = 2'd2, U_D = 2'd3} unit_e;
    typedef enum logic [1:0] {W_ONE = 2'd0, W_P40 = 2'd1, W_P64 = 2'd2, W_QUAD = 2'd3} wcls_e;
    typedef enum logic [1:0] {M_NONE = 2'd0, M_LD = 2'd1, M_ST = 2'd2, M_RSV = 2'd3} memop_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_SHOW = 1'b1} ctl_state_e;

    typedef struct packed {
        logic             ctrl;
        logic             compact;
        logic             pinv;
        logic [REG_W-1:0] preg;
        logic             pside;
        logic             pen;
        logic             st_side;
        memop_e           mem;
        logic             axp;
        logic [REG_W-1:0] base;
        wcls_e            wcls;
        logic             dst_side;
        logic [REG_W-1:0] dst;
        logic             dxp;
        logic             side;
        unit_e            unit;
        logic             vld;
    } desc_t;
endpackage

// File: rtl/slot_check.sv
module slot_check
    import pkt_rule_pkg::*;
(
    input  desc_t            d_i,
    output logic [NUNIT-1:0] unit_oh_o,
    output logic             dxp_a_o,
    output logic             dxp_b_o,
    output logic             axp_a_o,
    output logic             axp_b_o,
    output logic             d_a_o,
    output logic             d_b_o,
    output logic [ERR_W-1:0] err_o
);
    logic is_d;
    logic ax_use;
    logic mem_x;
    logic reg_side;
    logic unused_fields;

    assign unused_fields = ^{d_i.dst, d_i.pinv, d_i.pside};

    always_comb begin
        is_d     = d_i.vld && (d_i.unit == U_D);
        ax_use   = is_d && d_i.axp;
        mem_x    = ax_use && ((d_i.mem == M_LD) || (d_i.mem == M_ST));
        reg_side = (d_i.mem == M_LD) ? d_i.dst_side : d_i.st_side;

        unit_oh_o = '0;
        if (d_i.vld) unit_oh_o[{d_i.side, d_i.unit}] = 1'b1;

        dxp_a_o = d_i.vld && d_i.dxp && !d_i.side;
        dxp_b_o = d_i.vld && d_i.dxp &&  d_i.side;
        axp_a_o = ax_use && !d_i.side;
        axp_b_o = ax_use &&  d_i.side;
        d_a_o   = is_d && !d_i.side;
        d_b_o   = is_d &&  d_i.side;

        err_o = '0;
        if (d_i.vld) begin
            err_o[E_DSIDE] = !mem_x && (d_i.dst_side != d_i.side);
            err_o[E_AXREG] = mem_x && (reg_side == d_i.side);
            unique case (d_i.wcls)
                W_P40, W_P64: err_o[E_ALIGN] = d_i.base[0];
                W_QUAD:       err_o[E_ALIGN] = |d_i.base[1:0];
                default:      err_o[E_ALIGN] = 1'b0;
            endcase
            err_o[E_PRED]  = d_i.pen && (d_i.preg > REG_W'(2));
            err_o[E_CMPCT] = d_i.compact && d_i.pen;
            err_o[E_CTRL]  = d_i.ctrl && !((d_i.unit == U_S) && d_i.side);
        end
    end
endmodule

// File: rtl/packet_rules.sv
module packet_rules
    import pkt_rule_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic [NSLOT-1:0][NUNIT-1:0] unit_oh_i,
    input  logic [NSLOT-1:0]            dxp_a_i,
    input  logic [NSLOT-1:0]            dxp_b_i,
    input  logic [NSLOT-1:0]            axp_a_i,
    input  logic [NSLOT-1:0]            axp_b_i,
    input  logic [NSLOT-1:0]            d_a_i,
    input  logic [NSLOT-1:0]            d_b_i,
    output logic [ERR_W-1:0]            err_o
);
    localparam int CW = $clog2(NSLOT + 1);

    logic [NUNIT-1:0] unit_over;

    genvar u;
    generate
        for (u = 0; u < NUNIT; u++) begin : g_unit
            always_comb begin
                logic [CW-1:0] n;
                n = '0;
                for (int s = 0; s < NSLOT; s++) n = n + CW'(unit_oh_i[s][u]);
                unit_over[u] = (n > CW'(1));
            end
        end
    endgenerate

    always_comb begin
        logic ax_a_any;
        logic ax_b_any;
        ax_a_any = |axp_a_i;
        ax_b_any = |axp_b_i;
        err_o = '0;
        err_o[E_DUP]   = |unit_over;
        err_o[E_XBA]   = ($countones(dxp_a_i) > 1);
        err_o[E_XAB]   = ($countones(dxp_b_i) > 1);
        err_o[E_AXDIR] = ($countones(axp_a_i) > 1) || ($countones(axp_b_i) > 1);
        err_o[E_AXMIX] = (|d_a_i) && (|d_b_i) && (ax_a_any != ax_b_any);
    end
endmodule

// File: rtl/pkt_rule_check.sv
module pkt_rule_check
    import pkt_rule_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld_i,
    input  logic [NSLOT*DESC_W-1:0] pkt_i,
    output logic                    out_vld_o,
    output logic                    legal_o,
    output logic [ERR_W-1:0]        err_o
);
    logic [NSLOT-1:0][NUNIT-1:0] unit_oh;
    logic [NSLOT-1:0]            dxp_a, dxp_b, axp_a, axp_b, d_a, d_b;
    logic [NSLOT-1:0][ERR_W-1:0] slot_err;
    logic [ERR_W-1:0]            pkt_err;
    logic [ERR_W-1:0]            err_c;
    logic [ERR_W-1:0]            err_q;
    logic                        legal_q;
    ctl_state_e                  st_q, st_d;

    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            slot_check u_slot (
                .d_i       (desc_t'(pkt_i[s*DESC_W +: DESC_W])),
                .unit_oh_o (unit_oh[s]),
                .dxp_a_o   (dxp_a[s]),
                .dxp_b_o   (dxp_b[s]),
                .axp_a_o   (axp_a[s]),
                .axp_b_o   (axp_b[s]),
                .d_a_o     (d_a[s]),
                .d_b_o     (d_b[s]),
                .err_o     (slot_err[s])
            );
        end
    endgenerate

    packet_rules #(.NSLOT(NSLOT)) u_rules (
        .unit_oh_i (unit_oh),
        .dxp_a_i   (dxp_a),
        .dxp_b_i   (dxp_b),
        .axp_a_i   (axp_a),
        .axp_b_i   (axp_b),
        .d_a_i     (d_a),
        .d_b_i     (d_b),
        .err_o     (pkt_err)
    );

    always_comb begin
        err_c = pkt_err;
        for (int k = 0; k < NSLOT; k++) err_c = err_c | slot_err[k];
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_vld_i)  st_d = ST_SHOW;
            ST_SHOW: if (!in_vld_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // verdict capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= '0;
            legal_q <= 1'b0;
        end else if (in_vld_i) begin
            err_q   <= err_c;
            legal_q <= ~|err_c;
        end
    end

    // outputs
    always_comb begin
        out_vld_o = (st_q == ST_SHOW);
        legal_o   = legal_q;
        err_o     = err_q;
    end
endmodule

// File: rtl/pkt_rule_check_sva.sv
module pkt_rule_check_sva
    import pkt_rule_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld_i,
    input logic [NSLOT*DESC_W-1:0] pkt_i,
    input logic                    out_vld_o,
    input logic                    legal_o,
    input logic [ERR_W-1:0]        err_o
);
    logic any_vld;
    logic any_cmp_pred;

    always_comb begin
        any_vld      = 1'b0;
        any_cmp_pred = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            any_vld = any_vld | pkt_i[s*DESC_W];
            any_cmp_pred = any_cmp_pred |
                (pkt_i[s*DESC_W] & pkt_i[s*DESC_W+30] & pkt_i[s*DESC_W+22]);
        end
    end

    a_r1_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> out_vld_o);
    a_r1_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> !out_vld_o);
    a_r1_hold_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> ($stable(err_o) && $stable(legal_o)));
    a_r2_legal_iff_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (legal_o == (err_o == '0)));
    a_r2_empty_is_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && !any_vld) |=> legal_o);
    a_r11_compact_pred: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && any_cmp_pred) |=> err_o[E_CMPCT]);
endmodule

bind pkt_rule_check pkt_rule_check_sva #(.NSLOT(NSLOT)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld_i  (in_vld_i),
    .pkt_i     (pkt_i),
    .out_vld_o (out_vld_o),
    .legal_o   (legal_o),
    .err_o     (err_o)
);

// File: tb/pkt_rule_check_tb_top.sv
module pkt_rule_check_tb_top;
    import pkt_rule_pkg::*;

    localparam int NS = 8;
    localparam int PW = NS * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [PW-1:0] pkt = '0;
    logic          out_vld;
    logic          legal;
    logic [10:0]   err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic        m_vld = 1'b0;
    logic        m_legal = 1'b0;
    logic [10:0] m_err = '0;

    always #10 clk = ~clk;

    pkt_rule_check #(.NSLOT(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld), .pkt_i(pkt),
        .out_vld_o(out_vld), .legal_o(legal), .err_o(err)
    );

    function automatic string tag(input int b);
        case (b)
            0: return "R3";  1: return "R4";  2: return "R4";  3: return "R5";
            4: return "R6";  5: return "R7";  6: return "R8";  7: return "R9";
            8: return "R10"; 9: return "R11"; default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference of the issue rules
    function automatic logic [10:0] ref_err(input logic [PW-1:0] p);
        logic [10:0] e = '0;
        int cnt[8];
        int xa = 0, xb = 0, aa = 0, ab = 0;
        bit dp[2];
        bit dx[2];
        foreach (cnt[i]) cnt[i] = 0;
        dp[0] = 0; dp[1] = 0; dx[0] = 0; dx[1] = 0;
        for (int s = 0; s < NS; s++) begin
            desc_t d;
            bit axu, memx, rs;
            d = desc_t'(p[s*32 +: 32]);
            if (!d.vld) continue;
            cnt[int'(d.side) * 4 + int'(d.unit)]++;
            if (d.dxp) begin if (d.side) xb++; else xa++; end
            axu  = (d.unit == U_D) && d.axp;
            memx = axu && (d.mem == M_LD || d.mem == M_ST);
            if (d.unit == U_D) begin
                dp[d.side] = 1;
                if (d.axp) dx[d.side] = 1;
            end
            if (axu) begin if (d.side) ab++; else aa++; end
            if (!memx && d.dst_side != d.side) e[3] = 1;
            if (memx) begin
                rs = (d.mem == M_LD) ? d.dst_side : d.st_side;
                if (rs == d.side) e[6] = 1;
            end
            if ((d.wcls == W_P40 || d.wcls == W_P64) && (d.base % 2 != 0)) e[7] = 1;
            if (d.wcls == W_QUAD && (d.base % 4 != 0)) e[7] = 1;
            if (d.pen && d.preg > 2) e[8] = 1;
            if (d.compact && d.pen) e[9] = 1;
            if (d.ctrl && !(d.unit == U_S && d.side)) e[10] = 1;
        end
        foreach (cnt[i]) if (cnt[i] > 1) e[0] = 1;
        if (xa > 1) e[1] = 1;
        if (xb > 1) e[2] = 1;
        if (aa > 1 || ab > 1) e[4] = 1;
        if (dp[0] && dp[1] && dx[0] != dx[1]) e[5] = 1;
        return e;
    endfunction

    // one cycle: drive at falling edge, compare after the next rising edge
    task automatic cycle(input logic v, input logic [PW-1:0] p);
        @(negedge clk);
        in_vld = v;
        pkt = p;
        if (v) begin
            m_err = ref_err(p);
            m_legal = (m_err == '0);
            m_vld = 1'b1;
        end else begin
            m_vld = 1'b0;
        end
        @(posedge clk);
        #5;
        chk("R1 out_vld", out_vld, m_vld);
        chk("R2 legal", legal, m_legal);
        for (int b = 0; b < 11; b++) chk(tag(b), err[b], m_err[b]);
    endtask

    function automatic desc_t mkd(input unit_e u, input logic sd);
        desc_t d = '0;
        d.vld = 1'b1;
        d.unit = u;
        d.side = sd;
        d.dst_side = sd;
        return d;
    endfunction

    function automatic logic [PW-1:0] put(input logic [PW-1:0] p, input int s, input desc_t d);
        logic [PW-1:0] r = p;
        r[s*32 +: 32] = d;
        return r;
    endfunction

    function automatic logic [PW-1:0] rand_pkt();
        logic [PW-1:0] p = '0;
        int perm[8];
        int xs;
        for (int i = 0; i < 8; i++) perm[i] = i;
        for (int i = 7; i > 0; i--) begin
            int j, t;
            j = $urandom_range(i, 0);
            t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        xs = $urandom_range(7, 0);
        for (int s = 0; s < NS; s++) begin
            desc_t d;
            d = mkd(unit_e'(perm[s] % 4), logic'(perm[s] / 4));
            d.vld = ($urandom_range(9, 0) < 8);
            d.dst = 5'($urandom_range(31, 0));
            d.wcls = wcls_e'($urandom_range(3, 0));
            d.base = 5'($urandom_range(31, 0));
            if (d.wcls == W_QUAD) d.base[1:0] = 2'b00;
            else if (d.wcls != W_ONE) d.base[0] = 1'b0;
            d.dxp = (s == xs);
            if (d.unit == U_D) d.mem = memop_e'($urandom_range(2, 0));
            d.pen = $urandom_range(1, 0);
            d.pside = $urandom_range(1, 0);
            d.preg = 5'($urandom_range(2, 0));
            d.pinv = $urandom_range(1, 0);
            d.compact = !d.pen && ($urandom_range(1, 0) == 1);
            d.ctrl = (d.unit == U_S) && d.side && ($urandom_range(1, 0) == 1);
            p = put(p, s, d);
        end
        if ($urandom_range(1, 0) == 1) begin
            int pos;
            pos = $urandom_range(PW - 1, 0);
            p[pos] = ~p[pos];
        end
        return p;
    endfunction

    initial begin
        #(20 * 190000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] p;
        desc_t d;
        logic [10:0] keep;
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        chk("R1 reset out_vld", out_vld, 0);
        chk("R1 reset legal", legal, 0);
        chk("R1 reset err", err, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 empty packet is legal
        cycle(1'b1, '0);
        chk("R2 empty legal", legal, 1);

        // R3 two L units on side A
        p = put('0, 0, mkd(U_L, 1'b0));
        p = put(p, 5, mkd(U_L, 1'b0));
        cycle(1'b1, p);
        chk("R3 duplicate unit", err, 11'h001);

        // R4 two cross paths into side A; one per direction is fine
        d = mkd(U_L, 1'b0); d.dxp = 1'b1; p = put('0, 0, d);
        d = mkd(U_M, 1'b0); d.dxp = 1'b1; p = put(p, 1, d);
        cycle(1'b1, p);
        chk("R4 B-to-A overuse", err, 11'h002);
        d = mkd(U_S, 1'b1); d.dxp = 1'b1; p = put(p, 1, d);
        cycle(1'b1, p);
        chk("R4 one each way legal", legal, 1);
        d = mkd(U_L, 1'b1); d.dxp = 1'b1; p = put(p, 0, d);
        cycle(1'b1, p);
        chk("R4 A-to-B overuse", err, 11'h004);

        // R5 destination on the wrong side
        d = mkd(U_M, 1'b1); d.dst_side = 1'b0;
        cycle(1'b1, put('0, 2, d));
        chk("R5 dest side", err, 11'h008);

        // R7 / R8 / R5 exemption: D.A load via address cross path, D.B without
        d = mkd(U_D, 1'b0); d.axp = 1'b1; d.mem = M_LD; d.dst_side = 1'b1;
        p = put('0, 0, d);
        p = put(p, 1, mkd(U_D, 1'b1));
        cycle(1'b1, p);
        chk("R7 mixed address cross path", err, 11'h020);
        d = mkd(U_D, 1'b1); d.axp = 1'b1; d.mem = M_ST; d.st_side = 1'b0;
        p = put(p, 1, d);
        cycle(1'b1, p);
        chk("R7 both use address cross path", legal, 1);
        d = mkd(U_D, 1'b0); d.axp = 1'b1; d.mem = M_LD;
        cycle(1'b1, put('0, 3, d));
        chk("R8 load reg own side", err, 11'h040);

        // R6 two side-A D slots with address cross path (duplicate too)
        d = mkd(U_D, 1'b0); d.axp = 1'b1; d.mem = M_ST; d.st_side = 1'b1;
        p = put('0, 0, d);
        p = put(p, 4, d);
        cycle(1'b1, p);
        chk("R6 address cross path overuse", err, 11'h011);

        // R9 alignment
        d = mkd(U_L, 1'b0); d.wcls = W_P64; d.base = 5'd3;
        cycle(1'b1, put('0, 0, d));
        chk("R9 odd pair base", err, 11'h080);
        d.wcls = W_QUAD; d.base = 5'd6;
        cycle(1'b1, put('0, 0, d));
        chk("R9 quad base 6", err, 11'h080);
        d.base = 5'd28;
        cycle(1'b1, put('0, 0, d));
        chk("R9 quad base 28 legal", legal, 1);

        // R10 predicate register range; invert has no effect
        d = mkd(U_S, 1'b0); d.pen = 1'b1; d.preg = 5'd3;
        cycle(1'b1, put('0, 0, d));
        chk("R10 predicate index 3", err, 11'h100);
        d.preg = 5'd2; d.pside = 1'b1; d.pinv = 1'b1;
        cycle(1'b1, put('0, 0, d));
        chk("R10 inverted B2 legal", legal, 1);

        // R11 compact and predicated
        d.compact = 1'b1;
        cycle(1'b1, put('0, 0, d));
        chk("R11 compact predicated", err, 11'h200);

        // R12 control access
        d = mkd(U_S, 1'b0); d.ctrl = 1'b1;
        cycle(1'b1, put('0, 0, d));
        chk("R12 control on S of A", err, 11'h400);
        keep = err;
        d.side = 1'b1; d.dst_side = 1'b1;
        cycle(1'b0, put('0, 0, d));
        chk("R1 hold on gap", err, keep);
        cycle(1'b1, put('0, 0, d));
        chk("R12 control on S of B legal", legal, 1);

        // R2 invalid slots ignored
        d = mkd(U_L, 1'b0); d.dst_side = 1'b1; d.vld = 1'b0;
        cycle(1'b1, put('0, 0, d));
        chk("R2 invalid slot ignored", legal, 1);

        // random stream, with gaps
        for (int n = 0; n < 3000; n++) begin
            cycle(($urandom_range(4, 0) != 0), rand_pkt());
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule